// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides whether a transaction seen on the primary side of a PCI-to-PCI bridge must be claimed and forwarded downstream. It takes the packed base and limit fields of the bridge header, the command-register space enables and the bridge-control legacy-video bit. From these it rebuilds three forwarding windows (I/O, plain memory, prefetchable memory) plus the fixed legacy video ranges, and compares the request address against the one window that applies to the request kind.

Each window is rebuilt from low-granularity register fields. The window registers keep only the upper address bits. The low nibble of an I/O or prefetchable register is a type code that selects whether an upper-address register extends the window. Limits are padded with ones down to the window granularity: 4 KB for I/O and 1 MB for memory. The decision is registered, so the outputs reflect the inputs sampled at the previous rising clock edge.

Top module: `brwin_decoder`

## Requirements
- R1: I/O base = `io_base_i[7:4]` in address bits 15:12, with bits 11:0 zero. When `io_base_i[3:0]` equals 1, `io_base_up_i` supplies bits 31:16. For any other type value, bits 31:16 are zero.
- R2: I/O limit is built the same way from `io_limit_i` and `io_limit_up_i` (using the type nibble of `io_limit_i`), with bits 11:0 forced to ones.
- R3: Memory base = `mem_base_i[15:4]` in bits 31:20. Memory limit = `mem_limit_i[15:4]` in bits 31:20 with bits 19:0 forced to ones. Bits 63:32 of both are zero, and the low nibbles are ignored.
- R4: Prefetchable base and limit take bits 31:20 from `pf_base_i[15:4]` and `pf_limit_i[15:4]`, and the limit has bits 19:0 set. When a register's low nibble equals 1, its 32-bit upper register supplies bits 63:32; otherwise those bits are zero.
- R5: A window hit is inclusive at both ends: base <= address <= limit.
- R6: A window whose limit is below its base forwards nothing.
- R7: The I/O window forwards only when `io_en_i` is 1. Both memory windows forward only when `mem_en_i` is 1.
- R8: `is_io_i`=1 tests only the I/O window. A memory request with `is_pf_i`=1 tests only the prefetchable window. A memory request with `is_pf_i`=0 tests only the plain memory window.
- R9: With `vga_en_i`=1, a memory request in 0xA0000–0xBFFFF and an I/O request in 0x3B0–0x3BB or 0x3C0–0x3DF hit the legacy range, compared on the full address. With `vga_en_i`=0 these ranges never hit. The legacy ranges do not depend on `io_en_i` or `mem_en_i`.
- R10: `win_o` is one-hot or zero: bit0 I/O, bit1 memory, bit2 prefetchable, bit3 legacy video. A standard-window hit takes precedence over a legacy hit. `hit_o` is 1 exactly when `win_o` is nonzero.
- R11: `hit_o` and `win_o` are registered: they show the decision for the inputs sampled at the previous rising edge, and they are zero while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_base_i | input | 8 | I/O base field, type code in bits 3:0 |
| io_limit_i | input | 8 | I/O limit field, type code in bits 3:0 |
| io_base_up_i | input | 16 | I/O base address bits 31:16 |
| io_limit_up_i | input | 16 | I/O limit address bits 31:16 |
| mem_base_i | input | 16 | Memory base field |
| mem_limit_i | input | 16 | Memory limit field |
| pf_base_i | input | 16 | Prefetchable base field, type code in bits 3:0 |
| pf_limit_i | input | 16 | Prefetchable limit field, type code in bits 3:0 |
| pf_base_up_i | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_up_i | input | 32 | Prefetchable limit address bits 63:32 |
| io_en_i | input | 1 | I/O space enable |
| mem_en_i | input | 1 | Memory space enable |
| vga_en_i | input | 1 | Legacy video range enable |
| addr_i | input | ADDR_W | Request address |
| is_io_i | input | 1 | Request is I/O (else memory) |
| is_pf_i | input | 1 | Memory request is prefetchable |
| hit_o | output | 1 | Forward decision |
| win_o | output | 4 | One-hot matching window |

## Verification
The bench probes each window at base, limit, one below the base and one above the limit. A design with an off-by-one compare or a missing pad would drop the top page or claim the neighbour. It toggles the type nibble while the upper registers stay nonzero, which catches upper words applied unconditionally or never. It inverts base and limit, so a design that treats an inverted window as wrapping would forward. It also drives legacy edge addresses under enable on and off, overlaps a memory window with the legacy range to expose a wrong precedence, and sends mismatched request kinds to windows that would otherwise match, which exposes any cross-steering.

// File: rtl/brwin_pkg.sv
package brwin_pkg;
  typedef enum logic [1:0] {
    WIN_IO  = 2'd0,
    WIN_MEM = 2'd1,
    WIN_PF  = 2'd2,
    WIN_VGA = 2'd3
  } win_e;

  localparam int NUM_WIN   = 4;
  localparam int NUM_STD   = 3;
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam logic [3:0] TYPE_WIDE = 4'h1;

  localparam logic [63:0] VGA_MEM_LO = 64'h000A_0000;
  localparam logic [63:0] VGA_MEM_HI = 64'h000B_FFFF;
  localparam logic [63:0] VGA_IO0_LO = 64'h0000_03B0;
  localparam logic [63:0] VGA_IO0_HI = 64'h0000_03BB;
  localparam logic [63:0] VGA_IO1_LO = 64'h0000_03C0;
  localparam logic [63:0] VGA_IO1_HI = 64'h0000_03DF;
endpackage

// File: rtl/brwin_span.sv
module brwin_span import brwin_pkg::*; #(
  parameter win_e KIND = WIN_MEM,
  parameter int   AW   = 64
) (
  input  logic [15:0]   base_lo_i,
  input  logic [15:0]   limit_lo_i,
  input  logic [31:0]   base_hi_i,
  input  logic [31:0]   limit_hi_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] limit_o
);
  generate
    if (KIND == WIN_IO) begin : g_io
      logic unused_io;
      assign unused_io = ^{base_lo_i[15:8], limit_lo_i[15:8],
                           base_hi_i[31:16], limit_hi_i[31:16]};
      always_comb begin
        base_o  = '0;
        limit_o = '0;
        base_o[15:IO_GRAN]  = base_lo_i[7:4];
        limit_o[15:IO_GRAN] = limit_lo_i[7:4];
        limit_o[IO_GRAN-1:0] = '1;
        if (base_lo_i[3:0] == TYPE_WIDE)  base_o[31:16]  = base_hi_i[15:0];
        if (limit_lo_i[3:0] == TYPE_WIDE) limit_o[31:16] = limit_hi_i[15:0];
      end
    end else if (KIND == WIN_PF) begin : g_pf
      always_comb begin
        base_o  = '0;
        limit_o = '0;
        base_o[31:MEM_GRAN]  = base_lo_i[15:4];
        limit_o[31:MEM_GRAN] = limit_lo_i[15:4];
        limit_o[MEM_GRAN-1:0] = '1;
        if (base_lo_i[3:0] == TYPE_WIDE)  base_o[63:32]  = base_hi_i;
        if (limit_lo_i[3:0] == TYPE_WIDE) limit_o[63:32] = limit_hi_i;
      end
    end else begin : g_mem
      logic unused_mem;
      assign unused_mem = ^{base_lo_i[3:0], limit_lo_i[3:0], base_hi_i, limit_hi_i};
      always_comb begin
        base_o  = '0;
        limit_o = '0;
        base_o[31:MEM_GRAN]  = base_lo_i[15:4];
        limit_o[31:MEM_GRAN] = limit_lo_i[15:4];
        limit_o[MEM_GRAN-1:0] = '1;
      end
    end
  endgenerate
endmodule

// File: rtl/brwin_cmp.sv
module brwin_cmp #(
  parameter int AW = 64
) (
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic open_w;
  assign open_w = en_i && (limit_i >= base_i);
  assign hit_o  = open_w && (addr_i >= base_i) && (addr_i <= limit_i);
endmodule

// File: rtl/brwin_legacy.sv
module brwin_legacy import brwin_pkg::*; #(
  parameter int AW = 64
) (
  input  logic          en_i,
  input  logic          is_io_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic mem_rng, io_rng0, io_rng1;
  assign mem_rng = (addr_i >= AW'(VGA_MEM_LO)) && (addr_i <= AW'(VGA_MEM_HI));
  assign io_rng0 = (addr_i >= AW'(VGA_IO0_LO)) && (addr_i <= AW'(VGA_IO0_HI));
  assign io_rng1 = (addr_i >= AW'(VGA_IO1_LO)) && (addr_i <= AW'(VGA_IO1_HI));
  assign hit_o   = en_i && (is_io_i ? (io_rng0 || io_rng1) : mem_rng);
endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder import brwin_pkg::*; #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        io_base_i,
  input  logic [7:0]        io_limit_i,
  input  logic [15:0]       io_base_up_i,
  input  logic [15:0]       io_limit_up_i,
  input  logic [15:0]       mem_base_i,
  input  logic [15:0]       mem_limit_i,
  input  logic [15:0]       pf_base_i,
  input  logic [15:0]       pf_limit_i,
  input  logic [31:0]       pf_base_up_i,
  input  logic [31:0]       pf_limit_up_i,
  input  logic              io_en_i,
  input  logic              mem_en_i,
  input  logic              vga_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_io_i,
  input  logic              is_pf_i,
  output logic              hit_o,
  output logic [NUM_WIN-1:0] win_o
);
  logic [15:0] lo_base [NUM_STD];
  logic [15:0] lo_lim  [NUM_STD];
  logic [31:0] hi_base [NUM_STD];
  logic [31:0] hi_lim  [NUM_STD];
  logic [ADDR_W-1:0] w_base [NUM_STD];
  logic [ADDR_W-1:0] w_lim  [NUM_STD];
  logic [NUM_STD-1:0] sel, space_en, std_hit;
  logic vga_hit;
  logic [NUM_WIN-1:0] win_d, win_q;

  assign lo_base[WIN_IO]  = {8'h00, io_base_i};
  assign lo_lim[WIN_IO]   = {8'h00, io_limit_i};
  assign hi_base[WIN_IO]  = {16'h0000, io_base_up_i};
  assign hi_lim[WIN_IO]   = {16'h0000, io_limit_up_i};
  assign lo_base[WIN_MEM] = mem_base_i;
  assign lo_lim[WIN_MEM]  = mem_limit_i;
  assign hi_base[WIN_MEM] = '0;
  assign hi_lim[WIN_MEM]  = '0;
  assign lo_base[WIN_PF]  = pf_base_i;
  assign lo_lim[WIN_PF]   = pf_limit_i;
  assign hi_base[WIN_PF]  = pf_base_up_i;
  assign hi_lim[WIN_PF]   = pf_limit_up_i;

  // request kind picks exactly one standard window
  assign sel[WIN_IO]  = is_io_i;
  assign sel[WIN_MEM] = !is_io_i && !is_pf_i;
  assign sel[WIN_PF]  = !is_io_i && is_pf_i;

  assign space_en[WIN_IO]  = io_en_i;
  assign space_en[WIN_MEM] = mem_en_i;
  assign space_en[WIN_PF]  = mem_en_i;

  for (genvar k = 0; k < NUM_STD; k++) begin : g_win
    brwin_span #(.KIND(win_e'(k)), .AW(ADDR_W)) u_span (
      .base_lo_i  (lo_base[k]),
      .limit_lo_i (lo_lim[k]),
      .base_hi_i  (hi_base[k]),
      .limit_hi_i (hi_lim[k]),
      .base_o     (w_base[k]),
      .limit_o    (w_lim[k])
    );
    brwin_cmp #(.AW(ADDR_W)) u_cmp (
      .en_i    (space_en[k] && sel[k]),
      .base_i  (w_base[k]),
      .limit_i (w_lim[k]),
      .addr_i  (addr_i),
      .hit_o   (std_hit[k])
    );
  end

  brwin_legacy #(.AW(ADDR_W)) u_legacy (
    .en_i    (vga_en_i),
    .is_io_i (is_io_i),
    .addr_i  (addr_i),
    .hit_o   (vga_hit)
  );

  // standard window has precedence over the legacy range
  assign win_d = (std_hit != '0) ? {1'b0, std_hit} : {vga_hit, {NUM_STD{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  assign win_o = win_q;
  assign hit_o = |win_q;

  AST_ONE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o)); // R10
  AST_IO_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_io_i && !io_en_i |=> !win_o[WIN_IO]); // R7
  AST_MEM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_io_i && !mem_en_i |=> !win_o[WIN_MEM] && !win_o[WIN_PF]); // R7
  AST_IO_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_io_i |=> !win_o[WIN_MEM] && !win_o[WIN_PF]); // R8
  AST_PF_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_io_i && !is_pf_i |=> !win_o[WIN_PF] && !win_o[WIN_IO]); // R8
  AST_VGA_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vga_en_i |=> !win_o[WIN_VGA]); // R9
endmodule

// File: tb/sim_brwin_decoder.sv
`timescale 1ns/1ps
module sim_brwin_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  io_b, io_l;
  logic [15:0] io_bu, io_lu;
  logic [15:0] mem_b, mem_l, pf_b, pf_l;
  logic [31:0] pf_bu, pf_lu;
  logic io_en, mem_en, vga_en, is_io, is_pf;
  logic [63:0] addr;
  logic hit;
  logic [3:0] win;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  brwin_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .io_base_i(io_b), .io_limit_i(io_l), .io_base_up_i(io_bu), .io_limit_up_i(io_lu),
    .mem_base_i(mem_b), .mem_limit_i(mem_l),
    .pf_base_i(pf_b), .pf_limit_i(pf_l), .pf_base_up_i(pf_bu), .pf_limit_up_i(pf_lu),
    .io_en_i(io_en), .mem_en_i(mem_en), .vga_en_i(vga_en),
    .addr_i(addr), .is_io_i(is_io), .is_pf_i(is_pf),
    .hit_o(hit), .win_o(win)
  );

  function automatic bit inside_rng(longint unsigned a, longint unsigned lo, longint unsigned hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // behavioural reference: {hit, win}
  function automatic logic [4:0] ref_out();
    longint unsigned a = addr;
    longint unsigned b, l;
    bit w_io, w_mem, w_pf, w_vga;
    logic [3:0] w;
    b = longint'(io_b >> 4) * 4096;
    if ((io_b & 8'h0F) == 8'h01) b += longint'(io_bu) * 65536;
    l = longint'(io_l >> 4) * 4096 + 4095;
    if ((io_l & 8'h0F) == 8'h01) l += longint'(io_lu) * 65536;
    w_io = is_io && io_en && inside_rng(a, b, l);
    b = longint'(mem_b >> 4) * 1048576;
    l = longint'(mem_l >> 4) * 1048576 + 1048575;
    w_mem = !is_io && !is_pf && mem_en && inside_rng(a, b, l);
    b = longint'(pf_b >> 4) * 1048576;
    if ((pf_b & 16'h000F) == 16'h0001) b += longint'(pf_bu) << 32;
    l = longint'(pf_l >> 4) * 1048576 + 1048575;
    if ((pf_l & 16'h000F) == 16'h0001) l += longint'(pf_lu) << 32;
    w_pf = !is_io && is_pf && mem_en && inside_rng(a, b, l);
    if (is_io) w_vga = vga_en && (inside_rng(a, 'h3B0, 'h3BB) || inside_rng(a, 'h3C0, 'h3DF));
    else       w_vga = vga_en && inside_rng(a, 'hA0000, 'hBFFFF);
    if (w_io || w_mem || w_pf) w = {1'b0, w_pf, w_mem, w_io};
    else                       w = {w_vga, 3'b000};
    return {(w != 4'b0), w};
  endfunction

  task automatic compare(input string tag, input logic [4:0] e);
    checks++;
    if ({hit, win} !== e) begin
      errors++;
      $display("FAIL %s addr=%h: got hit=%0b win=%b expected hit=%0b win=%b",
               tag, addr, hit, win, e[4], e[3:0]);
    end
  endtask

  // inputs are set before call (between negedge and posedge); checked next negedge
  task automatic step(input string tag);
    logic [4:0] e;
    e = ref_out();
    @(posedge clk);
    @(negedge clk);
    compare(tag, e);
  endtask

  task automatic probe(input string tag, input bit io, input bit pf, input logic [63:0] a);
    is_io = io; is_pf = pf; addr = a;
    step(tag);
  endtask

  task automatic clear_all();
    io_b = 8'h00; io_l = 8'h00; io_bu = 16'h0; io_lu = 16'h0;
    mem_b = 16'hFFF0; mem_l = 16'h0000; pf_b = 16'hFFF0; pf_l = 16'h0000;
    pf_bu = 32'h0; pf_lu = 32'h0;
    io_en = 1'b1; mem_en = 1'b1; vga_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    clear_all();
    io_b = 8'h00; io_l = 8'hF0; mem_b = 16'h0000; mem_l = 16'hFFF0;
    is_io = 1'b0; is_pf = 1'b0; addr = 64'h1000; vga_en = 1'b1;
    repeat (3) @(negedge clk);
    compare("R11 reset", 5'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: output changes only after the edge
    clear_all();
    mem_b = 16'h0010; mem_l = 16'h0010;
    probe("R11 hit", 1'b0, 1'b0, 64'h0010_0000);
    addr = 64'h0090_0000;
    #1; compare("R11 hold", 5'b1_0010);
    step("R11 miss");

    // R1/R2 narrow I/O window, upper words ignored
    clear_all();
    io_b = 8'h20; io_l = 8'h30; io_bu = 16'h0001; io_lu = 16'h0001;
    probe("R1 io16 base", 1'b1, 1'b0, 64'h2000);
    probe("R1 io16 below", 1'b1, 1'b0, 64'h1FFF);
    probe("R2 io16 limit", 1'b1, 1'b0, 64'h3FFF);
    probe("R2 io16 above", 1'b1, 1'b0, 64'h4000);
    probe("R1 io16 upper ignored", 1'b1, 1'b0, 64'h0001_2000);
    // R1/R2 wide I/O window
    io_b = 8'h21; io_l = 8'h31;
    probe("R1 io32 base", 1'b1, 1'b0, 64'h0001_2000);
    probe("R1 io32 no upper", 1'b1, 1'b0, 64'h0000_2000);
    probe("R2 io32 limit", 1'b1, 1'b0, 64'h0001_3FFF);
    probe("R2 io32 above", 1'b1, 1'b0, 64'h0001_4000);

    // R3 memory window
    clear_all();
    mem_b = 16'h001F; mem_l = 16'h0021;
    probe("R3 mem base", 1'b0, 1'b0, 64'h0010_0000);
    probe("R3 mem below", 1'b0, 1'b0, 64'h000F_FFFF);
    probe("R5 mem limit", 1'b0, 1'b0, 64'h002F_FFFF);
    probe("R5 mem above", 1'b0, 1'b0, 64'h0030_0000);
    probe("R3 mem high bits", 1'b0, 1'b0, 64'h1_0010_0000);

    // R4 prefetchable window, wide and narrow
    clear_all();
    pf_b = 16'h0011; pf_l = 16'h0011; pf_bu = 32'h2; pf_lu = 32'h2;
    probe("R4 pf64 base", 1'b0, 1'b1, 64'h2_0010_0000);
    probe("R4 pf64 limit", 1'b0, 1'b1, 64'h2_001F_FFFF);
    probe("R4 pf64 above", 1'b0, 1'b1, 64'h2_0020_0000);
    probe("R4 pf64 no upper", 1'b0, 1'b1, 64'h0_0010_0000);
    pf_b = 16'h0010; pf_l = 16'h0010;
    probe("R4 pf32 base", 1'b0, 1'b1, 64'h0_0010_0000);
    probe("R4 pf32 upper ignored", 1'b0, 1'b1, 64'h2_0010_0000);

    // R6 inverted windows
    clear_all();
    mem_b = 16'h0050; mem_l = 16'h0040;
    probe("R6 mem empty mid", 1'b0, 1'b0, 64'h0045_0000);
    probe("R6 mem empty base", 1'b0, 1'b0, 64'h0050_0000);
    probe("R6 mem empty limit", 1'b0, 1'b0, 64'h0040_0000);
    io_b = 8'h51; io_l = 8'h41; io_bu = 16'h0; io_lu = 16'h0;
    probe("R6 io empty", 1'b1, 1'b0, 64'h4800);

    // R7 space enables
    clear_all();
    io_b = 8'h10; io_l = 8'h10; mem_b = 16'h0010; mem_l = 16'h0010;
    pf_b = 16'h0020; pf_l = 16'h0020;
    io_en = 1'b0;
    probe("R7 io disabled", 1'b1, 1'b0, 64'h1000);
    probe("R7 mem unaffected by io_en", 1'b0, 1'b0, 64'h0010_0000);
    io_en = 1'b1; mem_en = 1'b0;
    probe("R7 mem disabled", 1'b0, 1'b0, 64'h0010_0000);
    probe("R7 pf disabled", 1'b0, 1'b1, 64'h0020_0000);
    probe("R7 io unaffected by mem_en", 1'b1, 1'b0, 64'h1000);

    // R8 steering
    mem_en = 1'b1;
    probe("R8 pf req in mem window", 1'b0, 1'b1, 64'h0010_0000);
    probe("R8 mem req in pf window", 1'b0, 1'b0, 64'h0020_0000);
    probe("R8 io req in mem window", 1'b1, 1'b0, 64'h0010_0000);
    probe("R8 mem req in io window", 1'b0, 1'b0, 64'h1000);
    probe("R8 pf hit", 1'b0, 1'b1, 64'h0020_0000);

    // R9 legacy ranges
    clear_all();
    vga_en = 1'b1; io_en = 1'b0; mem_en = 1'b0;
    probe("R9 io 3AF", 1'b1, 1'b0, 64'h3AF);
    probe("R9 io 3B0", 1'b1, 1'b0, 64'h3B0);
    probe("R9 io 3BB", 1'b1, 1'b0, 64'h3BB);
    probe("R9 io 3BC", 1'b1, 1'b0, 64'h3BC);
    probe("R9 io 3C0", 1'b1, 1'b0, 64'h3C0);
    probe("R9 io 3DF", 1'b1, 1'b0, 64'h3DF);
    probe("R9 io 3E0", 1'b1, 1'b0, 64'h3E0);
    probe("R9 io alias", 1'b1, 1'b0, 64'h13B0);
    probe("R9 mem 9FFFF", 1'b0, 1'b0, 64'h9FFFF);
    probe("R9 mem A0000", 1'b0, 1'b1, 64'hA0000);
    probe("R9 mem BFFFF", 1'b0, 1'b0, 64'hBFFFF);
    probe("R9 mem C0000", 1'b0, 1'b0, 64'hC0000);
    probe("R9 io addr as mem", 1'b0, 1'b0, 64'h3B0);
    vga_en = 1'b0;
    probe("R9 off io", 1'b1, 1'b0, 64'h3C0);
    probe("R9 off mem", 1'b0, 1'b0, 64'hA8000);

    // R10 precedence over legacy
    clear_all();
    vga_en = 1'b1; mem_b = 16'h0000; mem_l = 16'h0000;
    probe("R10 mem over legacy", 1'b0, 1'b0, 64'hA0000);
    io_b = 8'h00; io_l = 8'h00;
    probe("R10 io over legacy", 1'b1, 1'b0, 64'h3C0);

    // R8/R10 mixed sweep against the reference
    for (int i = 0; i < 400; i++) begin
      io_b   = 8'($urandom) & 8'hF1;  io_l  = 8'($urandom) & 8'hF1;
      io_bu  = 16'($urandom_range(0, 1)); io_lu = 16'($urandom_range(0, 1));
      mem_b  = 16'($urandom_range(0, 16'h0040)); mem_l = 16'($urandom_range(0, 16'h0040));
      pf_b   = 16'($urandom_range(0, 16'h0040)); pf_l  = 16'($urandom_range(0, 16'h0040));
      pf_bu  = 32'($urandom_range(0, 1)); pf_lu = 32'($urandom_range(0, 1));
      io_en  = 1'($urandom); mem_en = 1'($urandom); vga_en = 1'($urandom);
      is_io  = 1'($urandom); is_pf = 1'($urandom);
      addr   = {31'h0, 1'($urandom), 8'h0, 24'($urandom_range(0, 24'h4F_FFFF))};
      if (i % 4 == 0) addr = 64'($urandom_range(0, 24'h0C_0000));
      step("R8 sweep");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule